// File: doc/BRIEF.md
# Decrement-and-Skip Execution Unit

This unit executes two single-word, 16-bit instructions of an 8-bit accumulator-style core. Both instructions decrement one byte of data memory. One skips the next instruction when the decremented value is zero. The other skips it when the value is nonzero. The decremented byte goes either to the working register or back to the data memory location it came from.

The data address is formed in one of two ways. A flag in the instruction selects either an externally held bank number or a fixed access window that covers the bottom and top of data memory. Each instruction cycle is four clocks long: decode, read, decrement, write. While one instruction executes, the next word is fetched into a prefetch register.

A skip cancels the word already fetched and runs a no-op cycle in its place. If the cancelled word opens a two-word instruction, a second no-op cycle consumes its second word. Every other instruction word is executed as a one-cycle operation with no effect on data memory or the working register.

Top module: `decskip_unit`

## Requirements
- R1: A word whose bits [15:10] are 6'b001011 is the decrement-skip-if-zero instruction, and 6'b010011 is the decrement-skip-if-nonzero instruction. In both, bit 9 is the destination flag, bit 8 is the bank flag and bits [7:0] are the register address. Any other word, including 0x2Bxx and 0x4Bxx, runs for one instruction cycle with no data write and no working-register change.
- R2: The decremented value is the 8-bit operand minus one, modulo 256 (0x00 becomes 0xFF).
- R3: With destination flag 0 the result goes to `wReg` and no data write takes place. With destination flag 1 exactly one data write of the result goes to the operand's address, and `wReg` is unchanged.
- R4: With bank flag 1 the data address is {bankSel, f}. With bank flag 0 it is {4{f[7]}, f}, so f = 0x00–0x7F maps to 0x000–0x07F and f = 0x80–0xFF maps to 0xF80–0xFFF.
- R5: `phase` counts 0,1,2,3 and repeats, one step per clock. Phase 3 ends an instruction cycle. The operand is read in phase 1, and the data write strobe is high only in phase 3.
- R6: The skip-if-zero form skips when the result is 0x00. The skip-if-nonzero form skips when the result is not 0x00. A skipped word runs as a no-op cycle with `execNop` = 1.
- R7: A first word with bits [15:12] = 4'hC or bits [15:10] = 6'b111011 opens a two-word instruction. Skipping it costs two no-op cycles; skipping any other word costs one.
- R8: `progAddr` is a byte address that advances by 2 every instruction cycle. `execAddr` is the byte address of the word executing. After a decrement-and-skip at address H, the next non-no-op cycle executes H+2 without a skip, H+4 after skipping a one-word instruction, and H+6 after skipping a two-word instruction.
- R9: During reset `progAddr` = 0, `phase` = 0, `wReg` = 0, `dataWe` = 0 and `execNop` = 1. After reset one no-op cycle runs, then the word at address 0 executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bankSel | input | 4 | Bank number used when the bank flag is 1 |
| progAddr | output | 12 | Byte address of the word being fetched |
| progData | input | 16 | Program word at `progAddr` |
| dataAddr | output | 12 | Data memory address |
| dataRdata | input | 8 | Data memory read value at `dataAddr` |
| dataWe | output | 1 | Data memory write strobe |
| dataWdata | output | 8 | Data memory write value |
| wReg | output | 8 | Working register |
| phase | output | 2 | Phase within the instruction cycle |
| execAddr | output | 12 | Byte address of the executing word |
| execNop | output | 1 | High while the executing word is cancelled |

## Verification
The assertions check these properties on every cycle:
- the phase steps once per clock;
- the fetch address steps by two at each cycle boundary;
- no more than one datapath strobe is high at a time;
- the working register changes only after its write strobe;
- the write address equals the read address;
- a cancelled cycle never writes.

Which word gets cancelled, how many no-op cycles follow, the arithmetic of the result, and the mapping of the access window depend on the operand value, the opcode and the fetched successor. Only the bench sweep shows these, by covering both opcodes, both flags, every operand value and both successor kinds.

// File: rtl/decskip_pkg.sv
package decskip_pkg;

  typedef struct packed {
    logic readOp;
    logic calc;
    logic writeF;
    logic writeW;
  } dsStrobe_t;

  localparam logic [5:0] OPC_DEC_SZ  = 6'b001011;
  localparam logic [5:0] OPC_DEC_SNZ = 6'b010011;

  function automatic logic isTwoWord(input logic [15:0] word);
    return (word[15:12] == 4'hC) || (word[15:10] == 6'b111011);
  endfunction

endpackage

// File: rtl/decskip_ctrl.sv
module decskip_ctrl
  import decskip_pkg::*;
#(
  parameter int PC_W = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [15:0]     progData,
  input  logic            resultZero,
  output logic [PC_W-1:0] progAddr,
  output logic [PC_W-1:0] execAddr,
  output logic            execNop,
  output logic [1:0]      phase,
  output logic [7:0]      regF,
  output logic            useBank,
  output dsStrobe_t       strobes
);

  localparam logic [1:0] PH_READ  = 2'd1;
  localparam logic [1:0] PH_CALC  = 2'd2;
  localparam logic [1:0] PH_WRITE = 2'd3;

  logic [1:0]      phaseQ;
  logic [PC_W-1:0] pcQ;
  logic [PC_W-1:0] execAddrQ;
  logic [15:0]     irQ;
  logic            nopQ;
  logic            secondPendQ;

  logic isDsz, isDsnz, active, toFile, skipNow, killNew;

  always_comb begin
    isDsz   = (irQ[15:10] == OPC_DEC_SZ);
    isDsnz  = (irQ[15:10] == OPC_DEC_SNZ);
    active  = !nopQ && (isDsz || isDsnz);
    toFile  = irQ[9];
    skipNow = active && (phaseQ == PH_WRITE) && (isDsz ? resultZero : !resultZero);
    killNew = skipNow || secondPendQ;
    strobes.readOp = active && (phaseQ == PH_READ);
    strobes.calc   = active && (phaseQ == PH_CALC);
    strobes.writeF = active && (phaseQ == PH_WRITE) && toFile;
    strobes.writeW = active && (phaseQ == PH_WRITE) && !toFile;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ      <= 2'd0;
      pcQ         <= '0;
      execAddrQ   <= '0;
      irQ         <= 16'h0000;
      nopQ        <= 1'b1;
      secondPendQ <= 1'b0;
    end else begin
      phaseQ <= phaseQ + 2'd1;
      if (phaseQ == PH_WRITE) begin
        irQ         <= progData;
        execAddrQ   <= pcQ;
        pcQ         <= pcQ + PC_W'(2);
        nopQ        <= killNew;
        secondPendQ <= skipNow && isTwoWord(progData);
      end
    end
  end

  assign progAddr = pcQ;
  assign execAddr = execAddrQ;
  assign execNop  = nopQ;
  assign phase    = phaseQ;
  assign regF     = irQ[7:0];
  assign useBank  = irQ[8];

  assert_phase_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (phaseQ == $past(phaseQ) + 2'd1));

  assert_pc_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_WRITE) |=> (pcQ == $past(pcQ) + PC_W'(2)));

  assert_strobe_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));

endmodule

// File: rtl/decskip_datapath.sv
module decskip_datapath
  import decskip_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BANK_W = 4,
  localparam int ADDR_W = BANK_W + 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dsStrobe_t         strobes,
  input  logic [7:0]        regF,
  input  logic              useBank,
  input  logic [BANK_W-1:0] bankSel,
  input  logic [DATA_W-1:0] dataRdata,
  output logic [ADDR_W-1:0] dataAddr,
  output logic [DATA_W-1:0] dataWdata,
  output logic              dataWe,
  output logic [DATA_W-1:0] wReg,
  output logic              resultZero
);

  logic [DATA_W-1:0] opndQ;
  logic [DATA_W-1:0] resultQ;
  logic [DATA_W-1:0] wRegQ;

  // The access window folds the top half of the register field onto the top of memory.
  always_comb begin
    if (useBank) dataAddr = {bankSel, regF};
    else         dataAddr = {{BANK_W{regF[7]}}, regF};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opndQ   <= '0;
      resultQ <= '0;
      wRegQ   <= '0;
    end else begin
      if (strobes.readOp) opndQ   <= dataRdata;
      if (strobes.calc)   resultQ <= opndQ - DATA_W'(1);
      if (strobes.writeW) wRegQ   <= resultQ;
    end
  end

  assign resultZero = (resultQ == '0);
  assign dataWdata  = resultQ;
  assign dataWe     = strobes.writeF;
  assign wReg       = wRegQ;

  assert_w_update_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wRegQ != $past(wRegQ)) |-> $past(strobes.writeW));

  assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    dataWe |-> (dataAddr == $past(dataAddr, 2)));

endmodule

// File: rtl/decskip_unit.sv
module decskip_unit
  import decskip_pkg::*;
#(
  parameter int PC_W   = 12,
  parameter int DATA_W = 8,
  parameter int BANK_W = 4,
  localparam int ADDR_W = BANK_W + 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BANK_W-1:0] bankSel,
  output logic [PC_W-1:0]   progAddr,
  input  logic [15:0]       progData,
  output logic [ADDR_W-1:0] dataAddr,
  input  logic [DATA_W-1:0] dataRdata,
  output logic              dataWe,
  output logic [DATA_W-1:0] dataWdata,
  output logic [DATA_W-1:0] wReg,
  output logic [1:0]        phase,
  output logic [PC_W-1:0]   execAddr,
  output logic              execNop
);

  dsStrobe_t  strobes;
  logic [7:0] regF;
  logic       useBank;
  logic       resultZero;

  decskip_ctrl #(.PC_W(PC_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .progData(progData), .resultZero(resultZero),
    .progAddr(progAddr), .execAddr(execAddr), .execNop(execNop), .phase(phase),
    .regF(regF), .useBank(useBank), .strobes(strobes)
  );

  decskip_datapath #(.DATA_W(DATA_W), .BANK_W(BANK_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regF(regF), .useBank(useBank),
    .bankSel(bankSel), .dataRdata(dataRdata), .dataAddr(dataAddr),
    .dataWdata(dataWdata), .dataWe(dataWe), .wReg(wReg), .resultZero(resultZero)
  );

  assert_nop_silent_R7: assert property (@(posedge clk) disable iff (!rstN)
    execNop |-> !dataWe);

endmodule

// File: tb/decskip_unit_tb_top.sv
module decskip_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 12;
  localparam int DATA_W = 8;
  localparam int BANK_W = 4;
  localparam int ADDR_W = BANK_W + 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [BANK_W-1:0] bankSel = '0;
  logic [PC_W-1:0] progAddr;
  logic [15:0] progData;
  logic [ADDR_W-1:0] dataAddr;
  logic [DATA_W-1:0] dataRdata;
  logic dataWe;
  logic [DATA_W-1:0] dataWdata;
  logic [DATA_W-1:0] wReg;
  logic [1:0] phase;
  logic [PC_W-1:0] execAddr;
  logic execNop;

  logic [15:0] prog [0:7];
  logic [7:0] dmem [0:4095];

  int checks = 0;
  int fails = 0;
  int writeCount = 0;
  logic [ADDR_W-1:0] lastWAddr;
  logic [7:0] lastWData;
  logic [1:0] lastWPhase;
  bit finished = 0;

  decskip_unit #(.PC_W(PC_W), .DATA_W(DATA_W), .BANK_W(BANK_W)) dut_i (
    .clk(clk), .rstN(rstN), .bankSel(bankSel), .progAddr(progAddr), .progData(progData),
    .dataAddr(dataAddr), .dataRdata(dataRdata), .dataWe(dataWe), .dataWdata(dataWdata),
    .wReg(wReg), .phase(phase), .execAddr(execAddr), .execNop(execNop)
  );

  assign progData  = prog[progAddr[3:1]];
  assign dataRdata = dmem[dataAddr];

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (dataWe) dmem[dataAddr] <= dataWdata;

  always @(negedge clk) begin
    if (rstN && dataWe) begin
      writeCount <= writeCount + 1;
      lastWAddr  <= dataAddr;
      lastWData  <= dataWdata;
      lastWPhase <= phase;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic runTrial(input bit form, input bit d, input bit a, input int v, input bit first);
    logic [7:0] f, res, val;
    logic [BANK_W-1:0] bank;
    logic [ADDR_W-1:0] expAddr;
    bit twoWord, skip;
    logic recNop [0:6];
    logic [PC_W-1:0] recAddr [0:6];
    int n, k, expNops, expNext;
    val = 8'(v);
    f = 8'((v * 37 + 11) & 255);
    bank = 4'(val[3:0] ^ {3'b000, form});
    expAddr = a ? {bank, f} : {{4{f[7]}}, f};
    res = val - 8'd1;
    twoWord = d ^ a;
    skip = form ? (res != 8'h00) : (res == 8'h00);
    prog[0] = {(form ? 6'b010011 : 6'b001011), d, a, f};
    if (twoWord) prog[1] = val[2] ? 16'hC0AB : 16'hEF12;
    else         prog[1] = {(form ? 8'h4B : 8'h2B), f};
    prog[2] = 16'hF034;
    for (int i = 3; i < 8; i++) prog[i] = 16'h0000;
    dmem[expAddr] = val;
    bankSel = bank;
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    writeCount = 0;
    if (first) begin
      check(progAddr == '0, "R9 reset progAddr", int'(progAddr), 0);
      check(phase == 2'd0, "R9 reset phase", int'(phase), 0);
      check(wReg == 8'h00, "R9 reset wReg", int'(wReg), 0);
      check(dataWe == 1'b0, "R9 reset dataWe", int'(dataWe), 0);
      check(execNop == 1'b1, "R9 reset execNop", int'(execNop), 1);
    end
    rstN = 1'b1;
    n = 0;
    while (n < 7) begin
      @(negedge clk);
      if (phase == 2'd3) begin
        recNop[n] = execNop;
        recAddr[n] = execAddr;
        n++;
      end
    end
    check(recNop[0] == 1'b1, "R9 first cycle no-op", int'(recNop[0]), 1);
    check(!recNop[1] && recAddr[1] == '0, "R9 word 0 runs second", int'(recAddr[1]), 0);
    k = 2;
    while (k < 6 && recNop[k]) k++;
    expNops = skip ? (twoWord ? 2 : 1) : 0;
    expNext = skip ? (twoWord ? 6 : 4) : 2;
    check((k - 2) == expNops, skip ? "R7 no-op cycle count" : "R6 no skip taken",
          k - 2, expNops);
    check(int'(recAddr[k]) == expNext, "R8 resume address", int'(recAddr[k]), expNext);
    if (d) begin
      check(writeCount == 1, "R3 one file write (R1 near-miss silent)", writeCount, 1);
      check(lastWAddr == expAddr, "R4 write address", int'(lastWAddr), int'(expAddr));
      check(lastWData == res, "R2 written value", int'(lastWData), int'(res));
      check(lastWPhase == 2'd3, "R5 write in last phase", int'(lastWPhase), 3);
      check(wReg == 8'h00, "R3 wReg untouched", int'(wReg), 0);
      check(dmem[expAddr] == res, "R2 memory result", int'(dmem[expAddr]), int'(res));
    end else begin
      check(writeCount == 0, "R3 no write for W dest (R1 near-miss silent)", writeCount, 0);
      check(wReg == res, "R2 wReg result", int'(wReg), int'(res));
      check(dmem[expAddr] == val, "R3 memory kept", int'(dmem[expAddr]), int'(val));
    end
  endtask

  initial begin
    bit first;
    first = 1;
    for (int form = 0; form < 2; form++)
      for (int d = 0; d < 2; d++)
        for (int a = 0; a < 2; a++)
          for (int v = 0; v < 256; v++) begin
            runTrial(form[0], d[0], a[0], v, first);
            first = 0;
          end
    finishRun();
  end

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    checks++;
    $display("FAIL watchdog: act=%0d exp=%0d", 1, 0);
    finishRun();
  end

endmodule